// File: doc/BRIEF.md
# Mode-Driven Firing Controller for a Dataflow Actor

This block decides, cycle by cycle, whether a dataflow actor is allowed to start one unit of work. It keeps the actor's current mode. For every mode it knows, from parameter tables, how many tokens that mode takes from each input edge and how many it adds to each output edge. The edge FIFOs are outside the block. They report only token counts: the population of each input FIFO, and the population and capacity of each output FIFO. The block never sees token values.

When the current mode is not terminal, every input holds enough tokens and every output has room for what the mode will add, the controller raises a one-cycle `fire` strobe to the datapath. It then waits. When the datapath pulses `done`, it also returns the single mode to use next, and the controller stores that mode for the next decision. Only one firing is ever outstanding.

A terminal mode, marked in a bit-vector parameter indexed by mode number, keeps the actor idle whatever the FIFOs hold. Only the external `mode_rst` input leaves such a mode, by sending the actor back to the parameterised initial mode.

Top module: `actor_fire_ctrl`

## Requirements
- R1: With the default tables, a fire may occur only when every input population is at least the current mode's consumption count. The default counts per mode, as (input 0, input 1), are: mode 0 (1,0), mode 1 (0,2), mode 2 (1,1), mode 3 (0,0).
- R2: A fire may occur only when, for every output, population plus the current mode's production count does not exceed capacity. Equality is allowed. The default production counts on the single output are: mode 0: 0, mode 1: 1, mode 2: 3, mode 3: 0.
- R3: In a terminal mode, `ready` and `fire` stay low whatever the FIFO counts are. The default terminal set is {mode 3}, which is bit 3 of the mask.
- R4: `fire` is high in an idle cycle exactly when `ready` is high and `mode_rst` and `rst` are low. It lasts one cycle, and `busy` is high from the next cycle on. `fire` never rises while `busy` is high.
- R5: A `done` pulse while `busy` clears `busy` and loads `next_mode` into `cur_mode` on the same clock edge. Enable is then evaluated again in the following cycle.
- R6: After `rst`, `cur_mode` equals the initial mode (0 by default), `busy` is low and `fire` is low.
- R7: `mode_rst` puts `cur_mode` back to the initial mode at the next edge and suppresses `fire` in its own cycle. It is the only way out of a terminal mode.
- R8: When `mode_rst` and `done` occur in the same busy cycle, the initial mode wins over `next_mode`, and `busy` still clears.
- R9: When `mode_rst` occurs while `busy` and `done` is absent, the actor keeps waiting. The `next_mode` returned with the later `done` is discarded, and the mode stays initial.
- R10: A `done` pulse while idle has no effect on `cur_mode` or `busy`.
- R11: `ready` shows the count-based enable condition for the current mode in every cycle, including busy cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_rst | input | 1 | Return the actor to its initial mode |
| in_pop | input | NUM_IN*CNT_W | Population of each input FIFO, edge e at bits e*CNT_W |
| out_pop | input | NUM_OUT*CNT_W | Population of each output FIFO |
| out_cap | input | NUM_OUT*CNT_W | Capacity of each output FIFO |
| done | input | 1 | Datapath has finished the firing in flight |
| next_mode | input | MODE_W | Mode returned by the datapath with `done` |
| fire | output | 1 | One-cycle start strobe to the datapath |
| ready | output | 1 | Enable condition of the current mode |
| busy | output | 1 | A firing is in flight |
| cur_mode | output | MODE_W | Mode used for the current enable check |

## Verification
Two collisions carry the most risk. The first is `mode_rst` in the same busy cycle as `done`, where the returned mode and the initial mode compete for the register. The second is `mode_rst` in an idle cycle where every count would otherwise allow a fire. Directed steps create each collision with FIFO counts that make `ready` high. A later random phase drives `mode_rst`, `done` and the counts independently, so the collisions also occur at arbitrary points. In every cycle, a behavioural model in the bench predicts `fire`, `ready`, `busy` and `cur_mode`, and each output is compared against that prediction.

// File: rtl/actor_fire_pkg.sv
package actor_fire_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic inputs_ok;
        logic outputs_ok;
        logic terminal;
    } gate_flags_t;

    function automatic int unsigned mode_bits(input int unsigned n_modes);
        return (n_modes > 1) ? $clog2(n_modes) : 1;
    endfunction

    function automatic int unsigned max_w(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/afc_rate_lookup.sv
module afc_rate_lookup #(
    parameter int unsigned NUM_MODES = 4,
    parameter int unsigned NUM_EDGES = 2,
    parameter int unsigned RATE_W    = 4,
    parameter int unsigned MODE_W    = 2,
    parameter logic [NUM_MODES*NUM_EDGES*RATE_W-1:0] TABLE = '0
) (
    input  logic [MODE_W-1:0]             mode,
    output logic [NUM_EDGES*RATE_W-1:0]   rates
);
    localparam int unsigned ROW_W = NUM_EDGES * RATE_W;

    always_comb begin
        rates = '0;
        for (int m = 0; m < NUM_MODES; m++) begin
            if (mode == MODE_W'(m)) begin
                rates = TABLE[m*ROW_W +: ROW_W];
            end
        end
    end
endmodule

// File: rtl/afc_in_gate.sv
module afc_in_gate #(
    parameter int unsigned NUM_EDGES = 2,
    parameter int unsigned CNT_W     = 6,
    parameter int unsigned RATE_W    = 4
) (
    input  logic [NUM_EDGES*CNT_W-1:0]  pop,
    input  logic [NUM_EDGES*RATE_W-1:0] need,
    output logic                        ok
);
    localparam int unsigned CMP_W = actor_fire_pkg::max_w(CNT_W, RATE_W) + 1;

    logic [NUM_EDGES-1:0] edge_ok;

    for (genvar e = 0; e < NUM_EDGES; e++) begin : g_edge
        logic [CMP_W-1:0] have_w;
        logic [CMP_W-1:0] need_w;
        assign have_w     = CMP_W'(pop[e*CNT_W +: CNT_W]);
        assign need_w     = CMP_W'(need[e*RATE_W +: RATE_W]);
        assign edge_ok[e] = (have_w >= need_w);
    end

    assign ok = &edge_ok;
endmodule

// File: rtl/afc_out_gate.sv
module afc_out_gate #(
    parameter int unsigned NUM_EDGES = 1,
    parameter int unsigned CNT_W     = 6,
    parameter int unsigned RATE_W    = 4
) (
    input  logic [NUM_EDGES*CNT_W-1:0]  pop,
    input  logic [NUM_EDGES*CNT_W-1:0]  cap,
    input  logic [NUM_EDGES*RATE_W-1:0] add,
    output logic                        ok
);
    localparam int unsigned SUM_W = actor_fire_pkg::max_w(CNT_W, RATE_W) + 1;

    logic [NUM_EDGES-1:0] edge_ok;

    for (genvar e = 0; e < NUM_EDGES; e++) begin : g_edge
        logic [SUM_W-1:0] after_w;
        logic [SUM_W-1:0] cap_w;
        assign after_w    = SUM_W'(pop[e*CNT_W +: CNT_W]) + SUM_W'(add[e*RATE_W +: RATE_W]);
        assign cap_w      = SUM_W'(cap[e*CNT_W +: CNT_W]);
        assign edge_ok[e] = (after_w <= cap_w);
    end

    assign ok = &edge_ok;
endmodule

// File: rtl/afc_sequencer.sv
module afc_sequencer
    import actor_fire_pkg::*;
#(
    parameter int unsigned MODE_W    = 2,
    parameter int unsigned INIT_MODE = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_rst,
    input  logic              go,
    input  logic              done,
    input  logic [MODE_W-1:0] next_mode,
    output logic              fire,
    output logic              busy,
    output logic [MODE_W-1:0] cur_mode
);
    localparam logic [MODE_W-1:0] START = MODE_W'(INIT_MODE);

    seq_state_e  st;
    logic        drop_ret;

    assign fire = (st == ST_IDLE) && go && !mode_rst && !rst;
    assign busy = (st == ST_BUSY);

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            drop_ret <= 1'b0;
            cur_mode <= START;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (fire) begin
                        st <= ST_BUSY;
                    end
                end
                ST_BUSY: begin
                    if (done) begin
                        st       <= ST_IDLE;
                        drop_ret <= 1'b0;
                        if (!mode_rst && !drop_ret) begin
                            cur_mode <= next_mode;
                        end
                    end else if (mode_rst) begin
                        drop_ret <= 1'b1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
            if (mode_rst) begin
                cur_mode <= START;
            end
        end
    end
endmodule

// File: rtl/actor_fire_ctrl.sv
module actor_fire_ctrl
    import actor_fire_pkg::*;
#(
    parameter int unsigned NUM_MODES = 4,
    parameter int unsigned NUM_IN    = 2,
    parameter int unsigned NUM_OUT   = 1,
    parameter int unsigned CNT_W     = 6,
    parameter int unsigned RATE_W    = 4,
    parameter int unsigned MODE_W    = actor_fire_pkg::mode_bits(NUM_MODES),
    parameter int unsigned INIT_MODE = 0,
    parameter logic [NUM_MODES-1:0] TERM_MASK = 4'b1000,
    parameter logic [NUM_MODES*NUM_IN*RATE_W-1:0]  CONS_TABLE = 32'h0011_2001,
    parameter logic [NUM_MODES*NUM_OUT*RATE_W-1:0] PROD_TABLE = 16'h0310
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     mode_rst,
    input  logic [NUM_IN*CNT_W-1:0]  in_pop,
    input  logic [NUM_OUT*CNT_W-1:0] out_pop,
    input  logic [NUM_OUT*CNT_W-1:0] out_cap,
    input  logic                     done,
    input  logic [MODE_W-1:0]        next_mode,
    output logic                     fire,
    output logic                     ready,
    output logic                     busy,
    output logic [MODE_W-1:0]        cur_mode
);
    localparam int unsigned MODE_SPACE = 1 << MODE_W;

    logic [NUM_IN*RATE_W-1:0]  need_rates;
    logic [NUM_OUT*RATE_W-1:0] add_rates;
    gate_flags_t               flags;

    afc_rate_lookup #(
        .NUM_MODES(NUM_MODES), .NUM_EDGES(NUM_IN), .RATE_W(RATE_W),
        .MODE_W(MODE_W), .TABLE(CONS_TABLE)
    ) u_cons (
        .mode(cur_mode), .rates(need_rates)
    );

    afc_rate_lookup #(
        .NUM_MODES(NUM_MODES), .NUM_EDGES(NUM_OUT), .RATE_W(RATE_W),
        .MODE_W(MODE_W), .TABLE(PROD_TABLE)
    ) u_prod (
        .mode(cur_mode), .rates(add_rates)
    );

    afc_in_gate #(
        .NUM_EDGES(NUM_IN), .CNT_W(CNT_W), .RATE_W(RATE_W)
    ) u_in_gate (
        .pop(in_pop), .need(need_rates), .ok(flags.inputs_ok)
    );

    afc_out_gate #(
        .NUM_EDGES(NUM_OUT), .CNT_W(CNT_W), .RATE_W(RATE_W)
    ) u_out_gate (
        .pop(out_pop), .cap(out_cap), .add(add_rates), .ok(flags.outputs_ok)
    );

    if (MODE_SPACE > NUM_MODES) begin : g_term_guarded
        always_comb begin
            flags.terminal = 1'b1;
            for (int m = 0; m < NUM_MODES; m++) begin
                if (cur_mode == MODE_W'(m)) begin
                    flags.terminal = TERM_MASK[m];
                end
            end
        end
    end else begin : g_term_direct
        assign flags.terminal = TERM_MASK[cur_mode];
    end

    assign ready = flags.inputs_ok && flags.outputs_ok && !flags.terminal;

    afc_sequencer #(
        .MODE_W(MODE_W), .INIT_MODE(INIT_MODE)
    ) u_seq (
        .clk(clk), .rst(rst), .mode_rst(mode_rst), .go(ready),
        .done(done), .next_mode(next_mode),
        .fire(fire), .busy(busy), .cur_mode(cur_mode)
    );
endmodule

// File: rtl/actor_fire_ctrl_chk.sv
module actor_fire_ctrl_chk #(
    parameter int unsigned NUM_MODES = 4,
    parameter int unsigned MODE_W    = 2,
    parameter int unsigned INIT_MODE = 0,
    parameter logic [NUM_MODES-1:0] TERM_MASK = '0
) (
    input logic              clk,
    input logic              rst,
    input logic              mode_rst,
    input logic              done,
    input logic              fire,
    input logic              ready,
    input logic              busy,
    input logic [MODE_W-1:0] cur_mode
);
    assert_fire_needs_ready_R4: assert property (@(posedge clk) disable iff (rst)
        fire |-> (ready && !busy && !mode_rst));

    assert_fire_single_R4: assert property (@(posedge clk) disable iff (rst)
        fire |=> (!fire && busy));

    assert_no_terminal_fire_R3: assert property (@(posedge clk) disable iff (rst)
        fire |-> ((int'(cur_mode) < NUM_MODES) && !TERM_MASK[cur_mode]));

    assert_done_clears_R5: assert property (@(posedge clk) disable iff (rst)
        (busy && done) |=> !busy);

    assert_wait_holds_R4: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy);

    assert_mode_restart_R7: assert property (@(posedge clk) disable iff (rst)
        mode_rst |=> (cur_mode == MODE_W'(INIT_MODE)));

    assert_idle_done_ignored_R10: assert property (@(posedge clk) disable iff (rst)
        (!busy && !fire && !mode_rst) |=> ($stable(cur_mode) && !busy));
endmodule

bind actor_fire_ctrl actor_fire_ctrl_chk #(
    .NUM_MODES(NUM_MODES), .MODE_W(MODE_W),
    .INIT_MODE(INIT_MODE), .TERM_MASK(TERM_MASK)
) u_chk (
    .clk(clk), .rst(rst), .mode_rst(mode_rst), .done(done),
    .fire(fire), .ready(ready), .busy(busy), .cur_mode(cur_mode)
);

// File: tb/actor_fire_ctrl_test.sv
module actor_fire_ctrl_test;
    localparam int CNT_W = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode_rst = 1'b0;
    logic [11:0] in_pop = '0;
    logic [5:0]  out_pop = '0;
    logic [5:0]  out_cap = '0;
    logic        done = 1'b0;
    logic [1:0]  next_mode = '0;
    logic        fire, ready, busy;
    logic [1:0]  cur_mode;

    actor_fire_ctrl uut (
        .clk(clk), .rst(rst), .mode_rst(mode_rst), .in_pop(in_pop),
        .out_pop(out_pop), .out_cap(out_cap), .done(done), .next_mode(next_mode),
        .fire(fire), .ready(ready), .busy(busy), .cur_mode(cur_mode)
    );

    always #10 clk = ~clk;

    int vectors = 0;
    int errors  = 0;
    bit ended   = 0;

    // behavioural model state
    int  m_mode = 0;
    bit  m_busy = 0;
    bit  m_drop = 0;
    int  cons [4][2] = '{'{1,0}, '{0,2}, '{1,1}, '{0,0}};
    int  prod [4]    = '{0, 1, 3, 0};
    bit  term [4]    = '{0, 0, 0, 1};

    function automatic bit model_ready();
        int p0 = int'(in_pop[0 +: CNT_W]);
        int p1 = int'(in_pop[CNT_W +: CNT_W]);
        if (term[m_mode]) return 0;
        if (p0 < cons[m_mode][0] || p1 < cons[m_mode][1]) return 0;
        if (int'(out_pop) + prod[m_mode] > int'(out_cap)) return 0;
        return 1;
    endfunction

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    endtask

    task automatic cmp(input string tag, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // one clock: drive, compare before edge, advance model at edge
    task automatic step(input string tag, input bit r, input bit mr, input int i0, input int i1,
                        input int op, input int oc, input bit dn, input int nm);
        bit exp_ready, exp_fire;
        @(negedge clk);
        rst = r; mode_rst = mr;
        in_pop = {CNT_W'(i1), CNT_W'(i0)};
        out_pop = CNT_W'(op); out_cap = CNT_W'(oc);
        done = dn; next_mode = 2'(nm);
        #1;
        exp_ready = model_ready();
        exp_fire  = !m_busy && exp_ready && !mr && !r;
        cmp(tag, "ready", int'(ready), int'(exp_ready));
        cmp(tag, "fire", int'(fire), int'(exp_fire));
        cmp(tag, "busy", int'(busy), int'(m_busy));
        cmp(tag, "cur_mode", int'(cur_mode), m_mode);
        @(posedge clk);
        if (r) begin
            m_mode = 0; m_busy = 0; m_drop = 0;
        end else if (m_busy && dn) begin
            if (!mr && !m_drop) m_mode = nm;
            m_busy = 0; m_drop = 0;
        end else if (m_busy && mr) begin
            m_drop = 1;
        end else if (exp_fire) begin
            m_busy = 1;
        end
        if (!r && mr) m_mode = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R6: reset state, with rich counts so a missing gate would show
        step("R6", 1, 0, 5, 5, 0, 10, 0, 0);
        step("R6", 1, 0, 5, 5, 0, 10, 0, 0);
        // R1: mode 0 lacks a token on input 0
        step("R1", 0, 0, 0, 9, 0, 10, 0, 0);
        step("R1", 0, 0, 0, 9, 0, 10, 0, 0);
        // R1/R4: token arrives, fire, then wait while ready stays high
        step("R1", 0, 0, 1, 0, 0, 0, 0, 0);
        step("R4", 0, 0, 1, 0, 0, 0, 0, 0);
        step("R4", 0, 0, 1, 0, 0, 0, 0, 0);
        step("R11", 0, 0, 1, 0, 0, 0, 0, 0);
        // R5: done returns mode 1
        step("R5", 0, 0, 1, 0, 0, 0, 1, 1);
        // mode 1 needs 2 on input 1 and room for 1
        step("R1", 0, 0, 9, 1, 0, 10, 0, 0);
        step("R2", 0, 0, 9, 2, 5, 5, 0, 0);
        step("R2", 0, 0, 9, 2, 4, 5, 0, 0);
        step("R5", 0, 0, 9, 2, 4, 5, 1, 2);
        // mode 2: exact room boundary then one short
        step("R2", 0, 0, 1, 1, 7, 10, 0, 0);
        step("R5", 0, 0, 1, 1, 7, 10, 1, 2);
        step("R2", 0, 0, 1, 1, 8, 10, 0, 0);
        // R10: done while idle is ignored
        step("R10", 0, 0, 1, 1, 8, 10, 1, 3);
        step("R10", 0, 0, 1, 1, 8, 10, 0, 0);
        // go to terminal mode 3
        step("R5", 0, 0, 1, 1, 0, 10, 0, 0);
        step("R5", 0, 0, 1, 1, 0, 10, 1, 3);
        for (int k = 0; k < 4; k++) step("R3", 0, 0, 9, 9, 0, 60, 0, 0);
        step("R3", 0, 0, 9, 9, 0, 60, 1, 1);
        step("R3", 0, 0, 9, 9, 0, 60, 0, 0);
        // R7: external restart leaves terminal mode; fire suppressed in that cycle
        step("R7", 0, 1, 9, 9, 0, 60, 0, 0);
        step("R7", 0, 1, 9, 9, 0, 60, 0, 0);
        step("R7", 0, 0, 9, 9, 0, 60, 0, 0);
        // R9: restart while busy, returned mode is dropped
        step("R9", 0, 1, 9, 9, 0, 60, 0, 0);
        step("R9", 0, 0, 9, 9, 0, 60, 0, 0);
        step("R9", 0, 0, 9, 9, 0, 60, 1, 2);
        step("R9", 0, 0, 9, 9, 0, 60, 0, 0);
        // R8: restart and done together
        step("R8", 0, 0, 9, 9, 0, 60, 1, 1);
        step("R8", 0, 0, 9, 9, 0, 60, 0, 0);
        step("R8", 0, 1, 9, 9, 0, 60, 1, 2);
        step("R8", 0, 0, 0, 0, 0, 60, 0, 0);
        // random phase covering all rules together
        for (int k = 0; k < 2000; k++) begin
            int unsigned rv = $urandom;
            step("R11", 0, (rv[4:0] == 0), int'(rv[7:5]), int'(rv[10:8]),
                 int'(rv[14:11]), int'(rv[18:15]), rv[19] & rv[20], int'(rv[22:21]));
        end
        finish_run();
    end
endmodule